// File: doc/BRIEF.md
# Flash unlock command decoder

This block is the command front end of a byte-wide parallel NOR flash model. Each bus write arrives as an address, a data byte and a strobe that is high for one clock. The decoder follows the multi-write unlock protocol: two fixed unlock writes, then a command write, and for erase a second pair of unlock writes and a final write that picks sector or chip. When a program, sector-erase or chip-erase sequence completes, it emits a one-cycle start pulse carrying the operation kind, the target address and the data byte of the final write. The storage array and the operation timer sit outside and consume this pulse.

The decoder also keeps the flag that selects identification mode, which is set by a three-write entry command and cleared either by a three-write exit command or by a single exit byte at any address. Any write that does not fit the expected step returns the decoder to plain read mode, except that a stray first unlock write begins a new sequence. While the external busy input is high, every write is discarded, the exit command included.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of a sequence, the decoder is in read mode: start_pulse, id_mode, op_type, op_addr and op_data are all 0, and a following data write launches nothing.
- R2: Writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by any address/data write raise start_pulse for exactly one cycle, the cycle after the fourth strobe, with op_type 2'b00, op_addr equal to the full fourth address and op_data equal to the fourth data.
- R3: Writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address launch a sector erase: op_type 2'b01, op_addr equal to the sixth address with bits 11..0 cleared, op_data 30h.
- R4: The same five writes followed by 10h@5555h launch a chip erase: op_type 2'b10, op_addr all zero, op_data 10h.
- R5: Writes AAh@5555h, 55h@2AAAh, 90h@5555h set id_mode in the cycle after the third strobe and launch nothing.
- R6: id_mode is cleared by the three-write sequence ending in F0h@5555h and also by a single F0h write at any address; an F0h byte written as program data (fourth write of R2) launches a program and leaves id_mode unchanged.
- R7: A write that does not match the expected step returns the decoder to read mode, so the remaining writes of the broken sequence launch nothing.
- R8: A mismatching write that is AAh@5555h is taken as a new first unlock write, so a complete sequence following it launches normally.
- R9: Only address bits 14..0 are compared against 5555h and 2AAAh; higher address bits do not affect unlock matching.
- R10: A write whose strobe coincides with busy high is ignored: no launch, no id_mode change (exit commands included), and the sequence position is kept so the sequence can resume after busy falls.
- R11: start_pulse is high only in the cycle following an accepted write strobe and never in two consecutive cycles; op_type is never 2'b11 during a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | AW (17) | Write address |
| wr_data | input | DW (8) | Write data byte |
| busy | input | 1 | Program or erase in progress; writes are discarded while high |
| start_pulse | output | 1 | One-cycle launch of a program or erase |
| op_type | output | 2 | 00 program, 01 sector erase, 10 chip erase |
| op_addr | output | AW (17) | Program byte address, sector base, or zero for chip erase |
| op_data | output | DW (8) | Data byte of the launching write |
| id_mode | output | 1 | Identification mode flag |

## Verification
The single-byte exit rule and the program data step can fall on the same write: with identification mode active, a program sequence is completed with F0h as its data byte, and the bench expects a program launch carrying F0h while id_mode stays set, then a lone F0h afterwards to clear it. The second collision is busy against a completing write: the fourth write of a program sequence is strobed while busy is high, and the bench expects no pulse, followed by a launch with the next write's address and data once busy has dropped. The same busy overlap is applied to a single F0h exit in identification mode, which must leave id_mode set.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

   // Sequence position of the unlock decoder
   typedef enum logic [2:0] {
      ST_READ = 3'd0,
      ST_UNL1 = 3'd1,
      ST_UNL2 = 3'd2,
      ST_PROG = 3'd3,
      ST_ERS3 = 3'd4,
      ST_ERS4 = 3'd5,
      ST_ERS5 = 3'd6
   } seq_state_t;

   // Operation kind carried on op_type
   typedef enum logic [1:0] {
      OP_PROG = 2'b00,
      OP_SECT = 2'b01,
      OP_CHIP = 2'b10
   } op_kind_t;

   // Command byte values
   localparam logic [7:0] CODE_UNLOCK1 = 8'hAA;
   localparam logic [7:0] CODE_UNLOCK2 = 8'h55;
   localparam logic [7:0] CODE_PROG    = 8'hA0;
   localparam logic [7:0] CODE_ERASE   = 8'h80;
   localparam logic [7:0] CODE_IDIN    = 8'h90;
   localparam logic [7:0] CODE_IDOUT   = 8'hF0;
   localparam logic [7:0] CODE_SECT    = 8'h30;
   localparam logic [7:0] CODE_CHIP    = 8'h10;

   // Which unlock steps the current write would satisfy
   typedef struct packed {
      logic first;      // AA at key A
      logic second;     // 55 at key B
      logic cmd_prog;   // A0 at key A
      logic cmd_erase;  // 80 at key A
      logic cmd_idin;   // 90 at key A
      logic any_exit;   // F0 at any address
      logic sect;       // 30 at any address
      logic chip;       // 10 at key A
   } step_hits_t;

endpackage

// File: rtl/nor_cmd_match.sv
module nor_cmd_match
   import nor_cmd_pkg::*;
#(
   parameter int unsigned KW     = 15,
   parameter int unsigned DW     = 8,
   parameter int unsigned ADDR_A = 'h5555,
   parameter int unsigned ADDR_B = 'h2AAA
) (
   input  logic [KW-1:0] key,
   input  logic [DW-1:0] data,
   output step_hits_t    hits
);

   localparam logic [KW-1:0] KEY_A = KW'(ADDR_A);
   localparam logic [KW-1:0] KEY_B = KW'(ADDR_B);

   logic at_a;
   logic at_b;
   logic [7:0] code;

   assign at_a = (key == KEY_A);
   assign at_b = (key == KEY_B);

   // Command bytes live in the low byte; a wider bus must keep the rest zero
   generate
      if (DW > 8) begin : g_wide
         logic hi_zero;
         assign hi_zero = (data[DW-1:8] == '0);
         assign code    = hi_zero ? data[7:0] : 8'h00;
      end else begin : g_byte
         assign code = data[7:0];
      end
   endgenerate

   always_comb begin
      hits.first     = at_a && (code == CODE_UNLOCK1);
      hits.second    = at_b && (code == CODE_UNLOCK2);
      hits.cmd_prog  = at_a && (code == CODE_PROG);
      hits.cmd_erase = at_a && (code == CODE_ERASE);
      hits.cmd_idin  = at_a && (code == CODE_IDIN);
      hits.any_exit  = (code == CODE_IDOUT);
      hits.sect      = (code == CODE_SECT);
      hits.chip      = at_a && (code == CODE_CHIP);
   end

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
   import nor_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic       busy,
   input  step_hits_t hits,
   output logic       launch,
   output op_kind_t   launch_kind,
   output logic       id_mode
);

   seq_state_t state;
   seq_state_t state_nx;
   logic       accept;
   logic       id_set;
   logic       id_clr;

   assign accept = wr_stb && !busy;

   always_comb begin
      seq_state_t restart;
      restart     = hits.first ? ST_UNL1 : ST_READ;
      state_nx    = state;
      launch      = 1'b0;
      launch_kind = OP_PROG;
      id_set      = 1'b0;
      id_clr      = 1'b0;
      if (accept) begin
         // An exit byte anywhere except the program data step leaves ID mode
         id_clr = hits.any_exit && (state != ST_PROG);
         case (state)
            ST_READ: state_nx = restart;
            ST_UNL1: state_nx = hits.second ? ST_UNL2 : restart;
            ST_UNL2: begin
               if (hits.cmd_prog)       state_nx = ST_PROG;
               else if (hits.cmd_erase) state_nx = ST_ERS3;
               else if (hits.cmd_idin) begin
                  id_set   = 1'b1;
                  state_nx = ST_READ;
               end else                 state_nx = restart;
            end
            ST_PROG: begin
               launch      = 1'b1;
               launch_kind = OP_PROG;
               state_nx    = ST_READ;
            end
            ST_ERS3: state_nx = hits.first ? ST_ERS4 : ST_READ;
            ST_ERS4: state_nx = hits.second ? ST_ERS5 : restart;
            ST_ERS5: begin
               if (hits.sect) begin
                  launch      = 1'b1;
                  launch_kind = OP_SECT;
                  state_nx    = ST_READ;
               end else if (hits.chip) begin
                  launch      = 1'b1;
                  launch_kind = OP_CHIP;
                  state_nx    = ST_READ;
               end else begin
                  state_nx = restart;
               end
            end
            default: state_nx = ST_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_READ;
         id_mode <= 1'b0;
      end else begin
         state <= state_nx;
         if (id_set)      id_mode <= 1'b1;
         else if (id_clr) id_mode <= 1'b0;
      end
   end

   // R10: a busy cycle leaves the ID flag as it was
   a_r10_busy_keeps_id: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(id_mode));

   // R10: a busy cycle leaves the sequence position as it was
   a_r10_busy_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(state));

   // R5: ID mode only turns on after an accepted write
   a_r5_id_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_mode) |-> $past(wr_stb && !busy));

   // R2: a program launch only happens from the data step
   a_r2_prog_from_data_step: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && launch_kind == OP_PROG) |-> (state == ST_PROG));

endmodule

// File: rtl/nor_cmd_launch.sv
module nor_cmd_launch
   import nor_cmd_pkg::*;
#(
   parameter int unsigned AW       = 17,
   parameter int unsigned DW       = 8,
   parameter int unsigned SECT_LSB = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  op_kind_t      launch_kind,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic          start_pulse,
   output logic [1:0]    op_type,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data
);

   logic [AW-1:0] sect_base;
   logic [AW-1:0] tgt_addr;

   generate
      if (SECT_LSB > 0) begin : g_sect_mask
         assign sect_base = {addr[AW-1:SECT_LSB], {SECT_LSB{1'b0}}};
      end else begin : g_sect_full
         assign sect_base = addr;
      end
   endgenerate

   always_comb begin
      case (launch_kind)
         OP_SECT: tgt_addr = sect_base;
         OP_CHIP: tgt_addr = '0;
         default: tgt_addr = addr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pulse <= 1'b0;
         op_type     <= 2'b00;
         op_addr     <= '0;
         op_data     <= '0;
      end else begin
         start_pulse <= launch;
         if (launch) begin
            op_type <= launch_kind;
            op_addr <= tgt_addr;
            op_data <= data;
         end
      end
   end

   // R11: the launch pulse is one cycle wide
   a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);

   // R11: unused operation code never launched
   a_r11_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (op_type != 2'b11));

   // R3: sector erase target is sector aligned
   a_r3_sector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (start_pulse && op_type == OP_SECT) |-> ((op_addr & AW'((1 << SECT_LSB) - 1)) == '0));

   // R4: chip erase carries a zero address
   a_r4_chip_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (start_pulse && op_type == OP_CHIP) |-> (op_addr == '0));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_cmd_pkg::*;
#(
   parameter int unsigned AW       = 17,
   parameter int unsigned DW       = 8,
   parameter int unsigned CMP_BITS = 15,
   parameter int unsigned SECT_LSB = 12,
   parameter int unsigned ADDR_A   = 'h5555,
   parameter int unsigned ADDR_B   = 'h2AAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          busy,
   output logic          start_pulse,
   output logic [1:0]    op_type,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data,
   output logic          id_mode
);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("nor_cmd_seq: DW must be at least 8");
      end
      if (AW < CMP_BITS) begin : g_bad_aw
         $error("nor_cmd_seq: AW must cover the compared address bits");
      end
      if (SECT_LSB >= AW) begin : g_bad_sect
         $error("nor_cmd_seq: SECT_LSB must lie inside the address");
      end
      if (ADDR_A == ADDR_B) begin : g_bad_keys
         $error("nor_cmd_seq: unlock addresses must differ");
      end
   endgenerate

   step_hits_t hits;
   logic       launch;
   op_kind_t   launch_kind;

   nor_cmd_match #(
      .KW     (CMP_BITS),
      .DW     (DW),
      .ADDR_A (ADDR_A),
      .ADDR_B (ADDR_B)
   ) u_match (
      .key  (wr_addr[CMP_BITS-1:0]),
      .data (wr_data),
      .hits (hits)
   );

   nor_cmd_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (wr_stb),
      .busy        (busy),
      .hits        (hits),
      .launch      (launch),
      .launch_kind (launch_kind),
      .id_mode     (id_mode)
   );

   nor_cmd_launch #(
      .AW       (AW),
      .DW       (DW),
      .SECT_LSB (SECT_LSB)
   ) u_launch (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (launch),
      .launch_kind (launch_kind),
      .addr        (wr_addr),
      .data        (wr_data),
      .start_pulse (start_pulse),
      .op_type     (op_type),
      .op_addr     (op_addr),
      .op_data     (op_data)
   );

   // R11: a pulse always follows a strobe
   a_r11_pulse_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(wr_stb));

   // R10: a write taken during busy never launches
   a_r10_busy_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !start_pulse);

endmodule

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;

   localparam int AW = 17;
   localparam int DW = 8;
   localparam int NV = 62;

   typedef struct packed {
      logic [3:0]    req;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic          busy;
      logic          pulse;
      logic [1:0]    typ;
      logic [AW-1:0] oaddr;
      logic [DW-1:0] odata;
      logic          id;
   } vec_t;

   // Stimulus and expected results after each write
   localparam vec_t VECS [NV] = '{
      // R2 program
      '{4'd2, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd2, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd2, 17'h05555, 8'hA0, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd2, 17'h1ABCD, 8'h3C, 1'b0, 1'b1, 2'd0, 17'h1ABCD, 8'h3C, 1'b0},
      // R3 sector erase, R9 high address bits set on unlock writes
      '{4'd9, 17'h1D555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd9, 17'h0AAAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd9, 17'h15555, 8'h80, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd3, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd3, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd3, 17'h13456, 8'h30, 1'b0, 1'b1, 2'd1, 17'h13000, 8'h30, 1'b0},
      // R4 chip erase
      '{4'd4, 17'h0D555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd4, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd4, 17'h1D555, 8'h80, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd4, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd4, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd4, 17'h05555, 8'h10, 1'b0, 1'b1, 2'd2, 17'h0,     8'h10, 1'b0},
      // R5 ID entry
      '{4'd5, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd5, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd5, 17'h05555, 8'h90, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b1},
      // R6 single-write exit at an arbitrary address
      '{4'd6, 17'h00123, 8'hF0, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd5, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd5, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd5, 17'h05555, 8'h90, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b1},
      // R6 three-write exit
      '{4'd6, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b1},
      '{4'd6, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b1},
      '{4'd6, 17'h05555, 8'hF0, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      // R7 wrong second step aborts the program sequence
      '{4'd7, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd7, 17'h02AAA, 8'h77, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd7, 17'h05555, 8'hA0, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd7, 17'h04000, 8'h12, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      // R8 AA@5555 in the command slot restarts the sequence
      '{4'd8, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd8, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd8, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd8, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd8, 17'h05555, 8'hA0, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd8, 17'h00010, 8'hFF, 1'b0, 1'b1, 2'd0, 17'h00010, 8'hFF, 1'b0},
      // R10 busy writes ignored, sequence resumes
      '{4'd10, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd10, 17'h02AAA, 8'h55, 1'b1, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd10, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd10, 17'h05555, 8'hA0, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd10, 17'h00020, 8'h5A, 1'b1, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd10, 17'h00021, 8'h5B, 1'b0, 1'b1, 2'd0, 17'h00021, 8'h5B, 1'b0},
      // R10 exit during busy is ignored
      '{4'd5, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd5, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd5, 17'h05555, 8'h90, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b1},
      '{4'd10, 17'h00000, 8'hF0, 1'b1, 1'b0, 2'd0, 17'h0,     8'h00, 1'b1},
      '{4'd6, 17'h00000, 8'hF0, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      // R6 F0 as program data while in ID mode
      '{4'd5, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd5, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd5, 17'h05555, 8'h90, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b1},
      '{4'd6, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b1},
      '{4'd6, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b1},
      '{4'd6, 17'h05555, 8'hA0, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b1},
      '{4'd6, 17'h00005, 8'hF0, 1'b0, 1'b1, 2'd0, 17'h00005, 8'hF0, 1'b1},
      '{4'd6, 17'h0FFFF, 8'hF0, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      // R7 wrong sixth step aborts the erase sequence
      '{4'd7, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd7, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd7, 17'h05555, 8'h80, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd7, 17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd7, 17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd7, 17'h00100, 8'h20, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0},
      '{4'd7, 17'h05555, 8'h10, 1'b0, 1'b0, 2'd0, 17'h0,     8'h00, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          busy = 1'b0;
   logic          start_pulse;
   logic [1:0]    op_type;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;
   logic          id_mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   nor_cmd_seq uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (wr_stb),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .busy        (busy),
      .start_pulse (start_pulse),
      .op_type     (op_type),
      .op_addr     (op_addr),
      .op_data     (op_data),
      .id_mode     (id_mode)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One write; returns at the falling edge after the capturing edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic b);
      @(negedge clk);
      wr_addr = a;
      wr_data = d;
      busy    = b;
      wr_stb  = 1'b1;
      @(negedge clk);
      wr_stb  = 1'b0;
      busy    = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      do_reset();
      // R1 reset state
      chk("R1", "start_pulse", 32'(start_pulse), 32'd0);
      chk("R1", "id_mode",     32'(id_mode),     32'd0);
      chk("R1", "op_type",     32'(op_type),     32'd0);
      chk("R1", "op_addr",     32'(op_addr),     32'd0);
      chk("R1", "op_data",     32'(op_data),     32'd0);

      // Vector table walk
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d row %0d", VECS[i].req, i);
         wr(VECS[i].addr, VECS[i].data, VECS[i].busy);
         chk(tag, "start_pulse", 32'(start_pulse), 32'(VECS[i].pulse));
         chk(tag, "id_mode",     32'(id_mode),     32'(VECS[i].id));
         if (VECS[i].pulse) begin
            chk(tag, "op_type", 32'(op_type), 32'(VECS[i].typ));
            chk(tag, "op_addr", 32'(op_addr), 32'(VECS[i].oaddr));
            chk(tag, "op_data", 32'(op_data), 32'(VECS[i].odata));
         end
      end

      // R2 / R11 pulse lasts one cycle and needs the strobe
      wr(17'h05555, 8'hAA, 1'b0);
      wr(17'h02AAA, 8'h55, 1'b0);
      wr(17'h05555, 8'hA0, 1'b0);
      @(negedge clk);
      wr_addr = 17'h00777;
      wr_data = 8'h42;
      repeat (3) @(negedge clk);
      chk("R11", "no pulse without strobe", 32'(start_pulse), 32'd0);
      wr(17'h00777, 8'h42, 1'b0);
      chk("R2", "pulse after data write", 32'(start_pulse), 32'd1);
      chk("R2", "op_addr", 32'(op_addr), 32'h00777);
      @(negedge clk);
      chk("R2", "pulse one cycle wide", 32'(start_pulse), 32'd0);
      chk("R11", "op_data held", 32'(op_data), 32'h42);

      // R1 reset in mid-sequence
      wr(17'h05555, 8'hAA, 1'b0);
      wr(17'h02AAA, 8'h55, 1'b0);
      wr(17'h05555, 8'hA0, 1'b0);
      do_reset();
      chk("R1", "op_addr after reset", 32'(op_addr), 32'd0);
      wr(17'h00009, 8'h99, 1'b0);
      chk("R1", "no launch after mid-sequence reset", 32'(start_pulse), 32'd0);

      // R1 reset clears ID mode
      wr(17'h05555, 8'hAA, 1'b0);
      wr(17'h02AAA, 8'h55, 1'b0);
      wr(17'h05555, 8'h90, 1'b0);
      chk("R5", "id entry", 32'(id_mode), 32'd1);
      do_reset();
      chk("R1", "id cleared by reset", 32'(id_mode), 32'd0);

      // R3 sector address at the top of the range
      wr(17'h05555, 8'hAA, 1'b0);
      wr(17'h02AAA, 8'h55, 1'b0);
      wr(17'h05555, 8'h80, 1'b0);
      wr(17'h05555, 8'hAA, 1'b0);
      wr(17'h02AAA, 8'h55, 1'b0);
      wr(17'h1FFFF, 8'h30, 1'b0);
      chk("R3", "top sector pulse", 32'(start_pulse), 32'd1);
      chk("R3", "top sector base", 32'(op_addr), 32'h1F000);
      chk("R3", "top sector type", 32'(op_type), 32'd1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule